// File: doc/BRIEF.md
# Packed BCD Byte Arithmetic Unit

This unit adds, subtracts or negates packed decimal bytes. Each byte holds two decimal digits: bits 7:4 are the tens digit and bits 3:0 the units digit. A carry-in extend flag enters every operation, and a zero flag enters as well, so a long decimal string can be worked one byte per clock. Software or a sequencer presents the least significant byte first, with the extend flag clear and the zero flag set. It then feeds the returned extend and zero flags back in with each higher byte.

The digit arithmetic is combinational: a ripple of per-digit units, each with its own decimal correction. One register stage captures the result and the flags on a valid strobe. A valid flag marks the cycle after each accepted operation. Digit codes above nine give results that are defined but carry no meaning.

Top module: `bcd_byte_alu`

## Requirements
- R1: With `op_sel` = 2'b00 (add), the captured result is (dst + src + x_in) mod 100 in packed decimal, and the carry is 1 exactly when that sum exceeds 99.
- R2: With `op_sel` = 2'b01 (subtract), the result is (dst − src − x_in) mod 100, and the borrow is 1 exactly when that difference is below zero.
- R3: With `op_sel` = 2'b10 (negate), `dst_byte` is ignored and the result is (0 − src − x_in) mod 100. This is the ten's complement of src when x_in is 0 and the nine's complement when x_in is 1. The borrow is set unless both src and x_in are zero.
- R4: `x_q` and `c_q` both take the decimal carry (add) or borrow (subtract, negate) out of the tens digit.
- R5: `z_q` becomes 0 when the result byte is nonzero and otherwise takes the value of `z_in`.
- R6: With `op_sel` = 2'b11, a valid strobe is ignored: all outputs keep their values and `res_vld` stays 0.
- R7: The outputs update at the rising edge where `op_valid` is high. `res_vld` is 1 for exactly the cycle that follows each accepted operation. Without a strobe the outputs hold.
- R8: While reset is asserted, and until the first accepted operation after it, `res_q`, `x_q`, `c_q`, `z_q` and `res_vld` are 0.
- R9: When both operands hold valid digits, each result digit is at most 9.
- R10: Feeding `x_q` and `z_q` back as `x_in` and `z_in` for successive bytes, least significant first, yields the correct multi-byte decimal sum, difference or negation. The final `z_q` is 1 only if every byte is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| op_valid | input | 1 | Strobe: capture this cycle's operation |
| op_sel | input | 2 | 00 add, 01 subtract, 10 negate, 11 no operation |
| src_byte | input | 8 | Source packed decimal byte |
| dst_byte | input | 8 | Destination packed decimal byte (unused by negate) |
| x_in | input | 1 | Incoming extend flag |
| z_in | input | 1 | Incoming zero flag |
| res_q | output | 8 | Registered packed decimal result |
| x_q | output | 1 | Registered extend flag |
| c_q | output | 1 | Registered carry/borrow flag |
| z_q | output | 1 | Registered zero flag |
| res_vld | output | 1 | High for one cycle after an accepted operation |

## Verification
Every result, flag and `res_vld` is due exactly one rising edge after the strobe that carries the operation, because the unit holds a single register stage. The bench changes inputs on falling edges and reads the outputs on the next falling edge, half a period after the capturing edge. It therefore compares each operation in the cycle after it is driven, and it can run back-to-back operations one per cycle. The hold and no-operation checks wait several edges and compare against the values recorded before the stimulus. The reset checks are taken during reset and again after the two-edge synchronised release.

// File: rtl/bcd_pkg.sv
package bcd_pkg;
  localparam int unsigned DIGIT_W = 4;

  typedef enum logic [1:0] {
    OP_ADD = 2'b00,
    OP_SUB = 2'b01,
    OP_NEG = 2'b10,
    OP_NOP = 2'b11
  } bcd_op_e;
endpackage

// File: rtl/bcd_rst_sync.sv
module bcd_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_ns
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_ns = sync_q[STAGES-1];
endmodule

// File: rtl/bcd_digit_unit.sv
module bcd_digit_unit
  import bcd_pkg::*;
(
  input  logic [DIGIT_W-1:0] a_dig,
  input  logic [DIGIT_W-1:0] b_dig,
  input  logic               cy_in,
  input  logic               do_sub,
  output logic [DIGIT_W-1:0] r_dig,
  output logic               cy_out
);
  logic [DIGIT_W:0] raw;

  always_comb begin
    if (!do_sub) begin
      // binary sum then +6 correction when above nine
      raw = {1'b0, a_dig} + {1'b0, b_dig} + {{DIGIT_W{1'b0}}, cy_in};
      if (raw > 5'd9) begin
        r_dig  = raw[DIGIT_W-1:0] + 4'd6;
        cy_out = 1'b1;
      end else begin
        r_dig  = raw[DIGIT_W-1:0];
        cy_out = 1'b0;
      end
    end else begin
      // binary difference then -6 correction on borrow
      raw = {1'b0, a_dig} - {1'b0, b_dig} - {{DIGIT_W{1'b0}}, cy_in};
      if (raw[DIGIT_W]) begin
        r_dig  = raw[DIGIT_W-1:0] - 4'd6;
        cy_out = 1'b1;
      end else begin
        r_dig  = raw[DIGIT_W-1:0];
        cy_out = 1'b0;
      end
    end
  end
endmodule

// File: rtl/bcd_core.sv
module bcd_core
  import bcd_pkg::*;
#(
  parameter int unsigned NDIG = 2,
  localparam int unsigned W   = NDIG * DIGIT_W
) (
  input  bcd_op_e        op,
  input  logic [W-1:0]   src,
  input  logic [W-1:0]   dst,
  input  logic           x_in,
  input  logic           z_in,
  output logic [W-1:0]   res,
  output logic           carry,
  output logic           z_out
);
  logic [W-1:0]  lhs;
  logic [NDIG:0] cy;
  logic          sub_mode;

  always_comb begin
    lhs      = (op == OP_NEG) ? '0 : dst;
    sub_mode = (op != OP_ADD);
  end

  assign cy[0] = x_in;

  for (genvar g = 0; g < NDIG; g++) begin : g_dig
    bcd_digit_unit u_dig (
      .a_dig  (lhs[g*DIGIT_W +: DIGIT_W]),
      .b_dig  (src[g*DIGIT_W +: DIGIT_W]),
      .cy_in  (cy[g]),
      .do_sub (sub_mode),
      .r_dig  (res[g*DIGIT_W +: DIGIT_W]),
      .cy_out (cy[g+1])
    );
  end

  assign carry = cy[NDIG];
  assign z_out = z_in & ~(|res);
endmodule

// File: rtl/bcd_byte_alu.sv
module bcd_byte_alu
  import bcd_pkg::*;
#(
  parameter int unsigned NDIG = 2,
  localparam int unsigned W   = NDIG * DIGIT_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         op_valid,
  input  logic [1:0]   op_sel,
  input  logic [W-1:0] src_byte,
  input  logic [W-1:0] dst_byte,
  input  logic         x_in,
  input  logic         z_in,
  output logic [W-1:0] res_q,
  output logic         x_q,
  output logic         c_q,
  output logic         z_q,
  output logic         res_vld
);
  logic         rst_ns;
  bcd_op_e      op;
  logic         accept;
  logic [W-1:0] core_res;
  logic         core_cy;
  logic         core_z;
  logic [W-1:0] res_d;
  logic         x_d, c_d, z_d, vld_d;

  bcd_rst_sync #(.STAGES(2)) u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .rst_ns (rst_ns)
  );

  assign op     = bcd_op_e'(op_sel);
  assign accept = op_valid && (op != OP_NOP);

  bcd_core #(.NDIG(NDIG)) u_core (
    .op    (op),
    .src   (src_byte),
    .dst   (dst_byte),
    .x_in  (x_in),
    .z_in  (z_in),
    .res   (core_res),
    .carry (core_cy),
    .z_out (core_z)
  );

  // next-state
  always_comb begin
    res_d = res_q;
    x_d   = x_q;
    c_d   = c_q;
    z_d   = z_q;
    vld_d = 1'b0;
    if (accept) begin
      res_d = core_res;
      x_d   = core_cy;
      c_d   = core_cy;
      z_d   = core_z;
      vld_d = 1'b1;
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      res_q   <= '0;
      x_q     <= 1'b0;
      c_q     <= 1'b0;
      z_q     <= 1'b0;
      res_vld <= 1'b0;
    end else begin
      res_q   <= res_d;
      x_q     <= x_d;
      c_q     <= c_d;
      z_q     <= z_d;
      res_vld <= vld_d;
    end
  end

  p_vld_after_accept_r7: assert property (@(posedge clk) disable iff (!rst_ns)
    accept |=> res_vld);

  p_no_vld_idle_r7: assert property (@(posedge clk) disable iff (!rst_ns)
    !accept |=> !res_vld);

  p_hold_on_nop_r6: assert property (@(posedge clk) disable iff (!rst_ns)
    !accept |=> ($stable(res_q) && $stable(x_q) && $stable(c_q) && $stable(z_q)));

  p_zero_cleared_r5: assert property (@(posedge clk) disable iff (!rst_ns)
    (accept && !z_in) |=> !z_q);

  p_flags_agree_r4: assert property (@(posedge clk) disable iff (!rst_ns)
    res_vld |-> (x_q == c_q));

  for (genvar g = 0; g < NDIG; g++) begin : g_chk
    p_digit_range_r9: assert property (@(posedge clk) disable iff (!rst_ns)
      (accept && src_byte[g*DIGIT_W +: DIGIT_W] <= 4'd9
              && dst_byte[g*DIGIT_W +: DIGIT_W] <= 4'd9)
      |=> (res_q[g*DIGIT_W +: DIGIT_W] <= 4'd9));
  end
endmodule

// File: tb/bcd_byte_alu_bench.sv
module bcd_byte_alu_bench;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       op_valid;
  logic [1:0] op_sel;
  logic [7:0] src_byte, dst_byte;
  logic       x_in, z_in;
  logic [7:0] res_q;
  logic       x_q, c_q, z_q, res_vld;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  always #5 clk = ~clk;

  bcd_byte_alu u_bcd_byte_alu (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_sel(op_sel),
    .src_byte(src_byte), .dst_byte(dst_byte), .x_in(x_in), .z_in(z_in),
    .res_q(res_q), .x_q(x_q), .c_q(c_q), .z_q(z_q), .res_vld(res_vld)
  );

  function automatic int dec(logic [7:0] b);
    return int'(b[7:4]) * 10 + int'(b[3:0]);
  endfunction

  function automatic logic [7:0] enc(int v);
    return {4'(v / 10), 4'(v % 10)};
  endfunction

  // returns {res, x, c, z}
  function automatic logic [10:0] ref_calc(int op, logic [7:0] s, logic [7:0] d,
                                           logic x, logic z);
    int v;
    logic cy;
    logic [7:0] r;
    case (op)
      0:       v = dec(d) + dec(s) + int'(x);
      1:       v = dec(d) - dec(s) - int'(x);
      default: v = 0 - dec(s) - int'(x);
    endcase
    if (op == 0) begin cy = (v > 99); if (cy) v -= 100; end
    else         begin cy = (v < 0);  if (cy) v += 100; end
    r = enc(v);
    return {r, cy, cy, z & (r == 8'h00)};
  endfunction

  task automatic check(string tag, bit ok, logic [15:0] got, logic [15:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  // drive on a falling edge, result read on the next falling edge
  task automatic run_op(int op, logic [7:0] s, logic [7:0] d, logic x, logic z,
                        string tag);
    logic [10:0] exp;
    op_valid = 1'b1; op_sel = 2'(op);
    src_byte = s; dst_byte = d; x_in = x; z_in = z;
    exp = ref_calc(op, s, d, x, z);
    @(negedge clk);
    check(tag, {res_q, x_q, c_q, z_q} == exp && res_vld,
          {4'h0, res_q, x_q, c_q, z_q, res_vld}, {4'h0, exp, 1'b1});
  endtask

  task automatic t_reset();
    rst_n = 1'b0; op_valid = 1'b0; op_sel = 2'b00;
    src_byte = 8'h00; dst_byte = 8'h00; x_in = 1'b0; z_in = 1'b0;
    repeat (3) @(negedge clk);
    check("R8 in reset", {res_q, x_q, c_q, z_q, res_vld} == 12'h000,
          {4'h0, res_q, x_q, c_q, z_q, res_vld}, 16'h0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R8 after release", {res_q, x_q, c_q, z_q, res_vld} == 12'h000,
          {4'h0, res_q, x_q, c_q, z_q, res_vld}, 16'h0);
  endtask

  // R1 / R2 / R3 / R4 / R5 / R9: every valid digit pair, both X values
  task automatic t_sweep(int op, string tag);
    for (int s = 0; s < 100; s++)
      for (int d = 0; d < 100; d++)
        for (int x = 0; x < 2; x++)
          run_op(op, enc(s), enc(d), 1'(x), 1'((s ^ d ^ x) & 1), tag);
    op_valid = 1'b0;
  endtask

  task automatic t_corners();
    run_op(0, 8'h99, 8'h99, 1'b1, 1'b1, "R1 max add 99+99+1");
    check("R9 digits valid", res_q == 8'h99, {8'h0, res_q}, 16'h0099);
    run_op(0, 8'h50, 8'h50, 1'b0, 1'b1, "R5 zero result keeps z");
    run_op(0, 8'h50, 8'h50, 1'b0, 1'b0, "R5 zero result z_in low");
    run_op(1, 8'h01, 8'h00, 1'b0, 1'b1, "R2 borrow 00-01");
    run_op(2, 8'h00, 8'h47, 1'b0, 1'b1, "R3 tens complement of zero");
    run_op(2, 8'h00, 8'h47, 1'b1, 1'b1, "R3 nines complement of zero");
    run_op(2, 8'h25, 8'h00, 1'b0, 1'b0, "R3 tens complement 25");
    check("R3 value 75", res_q == 8'h75, {8'h0, res_q}, 16'h0075);
    run_op(2, 8'h25, 8'h00, 1'b1, 1'b0, "R3 nines complement 25");
    check("R3 value 74", res_q == 8'h74 && x_q && c_q, {7'h0, res_q, x_q},
          {7'h0, 8'h74, 1'b1});
    check("R4 x equals c", x_q == c_q, {15'h0, x_q}, {15'h0, c_q});
    // dst ignored by negate: two differing dst give same result
    run_op(2, 8'h38, 8'h99, 1'b0, 1'b1, "R3 dst ignored a");
    run_op(2, 8'h38, 8'h12, 1'b0, 1'b1, "R3 dst ignored b");
    op_valid = 1'b0;
  endtask

  task automatic t_hold_nop();
    logic [10:0] snap;
    run_op(0, 8'h12, 8'h34, 1'b1, 1'b1, "R7 setup");
    snap = {res_q, x_q, c_q, z_q};
    op_valid = 1'b0; op_sel = 2'b00; src_byte = 8'h77; dst_byte = 8'h66;
    x_in = 1'b0; z_in = 1'b0;
    repeat (3) @(negedge clk);
    check("R7 hold without strobe", {res_q, x_q, c_q, z_q} == snap && !res_vld,
          {4'h0, res_q, x_q, c_q, z_q, res_vld}, {4'h0, snap, 1'b0});
    op_valid = 1'b1; op_sel = 2'b11; src_byte = 8'h99; dst_byte = 8'h99;
    x_in = 1'b1; z_in = 1'b0;
    @(negedge clk);
    check("R6 nop strobe ignored", {res_q, x_q, c_q, z_q} == snap && !res_vld,
          {4'h0, res_q, x_q, c_q, z_q, res_vld}, {4'h0, snap, 1'b0});
    repeat (2) @(negedge clk);
    check("R6 nop held", {res_q, x_q, c_q, z_q} == snap && !res_vld,
          {4'h0, res_q, x_q, c_q, z_q, res_vld}, {4'h0, snap, 1'b0});
    op_valid = 1'b0;
    @(negedge clk);
    check("R7 vld pulse ends", !res_vld, {15'h0, res_vld}, 16'h0);
  endtask

  // R10: four-digit strings, low byte first, flags fed back from the outputs
  task automatic t_chain(int op, int a, int b);
    int expv;
    logic exp_cy, exp_z;
    logic [15:0] got;
    logic xf, zf;
    case (op)
      0:       expv = a + b;
      1:       expv = a - b;
      default: expv = 0 - b;
    endcase
    exp_cy = (expv < 0) || (expv > 9999);
    expv   = (expv + 10000) % 10000;
    exp_z  = (expv == 0);
    xf = 1'b0; zf = 1'b1;
    for (int i = 0; i < 2; i++) begin
      op_valid = 1'b1; op_sel = 2'(op);
      dst_byte = enc(i == 0 ? a % 100 : a / 100);
      src_byte = enc(i == 0 ? b % 100 : b / 100);
      x_in = xf; z_in = zf;
      @(negedge clk);
      got[i*8 +: 8] = res_q;
      xf = x_q; zf = z_q;
    end
    op_valid = 1'b0;
    check("R10 chained value", got == {enc(expv / 100), enc(expv % 100)},
          got, {enc(expv / 100), enc(expv % 100)});
    check("R10 chained flags", xf == exp_cy && zf == exp_z,
          {14'h0, xf, zf}, {14'h0, exp_cy, exp_z});
  endtask

  initial begin
    t_reset();
    @(negedge clk);
    t_sweep(0, "R1 add sweep");
    t_sweep(1, "R2 sub sweep");
    t_sweep(2, "R3 neg sweep");
    t_corners();
    t_hold_nop();
    t_chain(0, 4729, 5386);
    t_chain(1, 5000, 5000);
    t_chain(1, 1200, 1300);
    t_chain(2, 0, 1);
    t_chain(2, 0, 0);
    t_chain(0, 9999, 1);
    @(negedge clk);
    finish_run();
  end
endmodule